// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Control

This block is the hazard controller for a five-stage integer pipeline (fetch, decode, execute, memory, write-back). A result is computed at the end of execute but reaches the register file only at write-back. For that reason the block picks, for each of the two execute operands, whether the value comes from the memory-stage result, the write-back result or the register file read.

The only dependency that a bypass cannot cover is a load in execute whose data a decode-stage instruction needs. For that case the block holds fetch and decode for one cycle and turns the execute slot into a bubble. In the next cycle the loaded value sits in write-back and is bypassed from there.

Branches resolve in execute. When one is taken, the block discards the two younger instructions. The discard wins over any hold that is requested in the same cycle.

The block is purely combinational. The clock and reset inputs serve only its embedded timing checks.

Top module: `hazard_unit`

## Requirements
- R1: An execute operand whose source index is nonzero, equals the memory-stage destination and has the memory-stage write enable set gets select code 2'b10 (memory result).
- R2: An execute operand with no memory-stage match, whose nonzero source equals the write-back destination with its write enable set, gets select code 2'b01 (write-back result).
- R3: When both the memory and the write-back stage match an operand, the memory stage wins and the select is 2'b10.
- R4: A source index of zero always gets select 2'b00 (register file), whatever the later stages hold.
- R5: A destination match whose write enable is low does not forward. With no other match the select is 2'b00.
- R6: A load in execute with write enable set and a nonzero destination equal to either decode source, with no taken branch, drives the fetch hold, the decode hold and the execute bubble all high.
- R7: A non-load in execute that matches a decode source causes no hold and no bubble.
- R8: A load in execute whose destination is zero, or whose write enable is low, causes no hold.
- R9: A taken branch drives both flush outputs high and forces the fetch hold, the decode hold and the execute bubble low, even when a load-use match is present.
- R10: Without a taken branch both flush outputs are low.
- R11: The two operand selects are decided independently, each from its own source index.
- R12: Select code 2'b11 never appears, and all outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset; disables the checks |
| id_src1 | input | REG_ADDR_W | First source index of the decode instruction |
| id_src2 | input | REG_ADDR_W | Second source index of the decode instruction |
| ex_src1 | input | REG_ADDR_W | First source index of the execute instruction |
| ex_src2 | input | REG_ADDR_W | Second source index of the execute instruction |
| ex_dst | input | REG_ADDR_W | Destination index in execute |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_ADDR_W | Destination index in memory |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_ADDR_W | Destination index in write-back |
| wb_wr | input | 1 | Write-back instruction writes a register |
| br_taken | input | 1 | Branch in execute resolved taken |
| opa_sel | output | 2 | Operand A source: 00 regfile, 01 write-back, 10 memory |
| opb_sel | output | 2 | Operand B source, same coding |
| hold_fetch | output | 1 | Keep the program counter |
| hold_decode | output | 1 | Keep the fetch/decode register |
| ex_bubble | output | 1 | Load a no-op into the decode/execute register |
| flush_fetch | output | 1 | Clear the fetch/decode register |
| flush_decode | output | 1 | Clear the decode/execute register |

## Verification
The bypass selects are swept over every combination of four register indices, zero included, for the operand source and the memory and write-back destinations, with both write enables toggled. This separates memory-first priority, the write-back fallback, zero-index suppression and disabled writes. Operand B carries a different index from operand A in every case, so a crossed wire between the operands shows. The hold and flush outputs are swept over all decode source pairs, execute destinations, load and write flags and branch outcomes. This tells a true load-use hold apart from a plain ALU dependency, a load to index zero and a taken branch that overrides the hold.

// File: rtl/hzu_pkg.sv
// Shared types for the hazard controller.
package hzu_pkg;
    // Source chosen for an execute operand; 2'b11 is unused.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } opnd_src_e;
endpackage

// File: rtl/opnd_bypass_sel.sv
// Chooses the source of one execute operand.
// Assumes: index zero is the constant-zero register and is never produced.
module opnd_bypass_sel
    import hzu_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr,
    output opnd_src_e     sel
);
    localparam logic [AW-1:0] ZERO_IDX = '0;

    logic src_live;
    logic mem_hit;
    logic wb_hit;

    // Qualify each stage's match: write enabled, same index, not index zero.
    always_comb begin
        src_live = (src != ZERO_IDX);
        mem_hit  = src_live && mem_wr && (mem_dst == src);
        wb_hit   = src_live && wb_wr  && (wb_dst  == src);
    end

    // Priority pick: youngest producer (memory) before write-back before regfile.
    always_comb begin
        if (mem_hit)     sel = SRC_MEM;
        else if (wb_hit) sel = SRC_WB;
        else             sel = SRC_REGFILE;
    end

    // R1/R2: a bypass select implies a live producer at that stage.
    p_mem_has_producer_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_MEM) |-> (mem_wr && mem_dst == src));
    p_wb_has_producer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_WB) |-> (wb_wr && wb_dst == src && !(mem_wr && mem_dst == src)));
    p_zero_from_rf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src == ZERO_IDX) |-> (sel == SRC_REGFILE));
endmodule

// File: rtl/load_use_detect.sv
// Flags a decode instruction that reads the destination of a load in execute.
// Assumes: the load data first becomes bypassable from write-back.
module load_use_detect #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_src1,
    input  logic [AW-1:0] id_src2,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_wr,
    input  logic          ex_load,
    output logic          hit
);
    localparam logic [AW-1:0] ZERO_IDX = '0;

    logic producing;

    // A load that really writes a nonzero register and a decode source equal to it.
    always_comb begin
        producing = ex_load && ex_wr && (ex_dst != ZERO_IDX);
        hit       = producing && ((id_src1 == ex_dst) || (id_src2 == ex_dst));
    end

    p_only_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ex_load);
    p_no_zero_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (ex_dst != ZERO_IDX && ex_wr));
endmodule

// File: rtl/pipe_flow_ctrl.sv
// Turns load-use and taken-branch events into hold, bubble and flush controls.
// Assumes: a branch resolves in execute, so both younger slots are wrong-path.
module pipe_flow_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic br_taken,
    input  logic load_hit,
    output logic hold_fetch,
    output logic hold_decode,
    output logic ex_bubble,
    output logic flush_fetch,
    output logic flush_decode
);
    logic do_hold;

    // A flush wins over a hold: the held instruction is wrong-path anyway.
    always_comb begin
        do_hold      = load_hit && !br_taken;
        hold_fetch   = do_hold;
        hold_decode  = do_hold;
        ex_bubble    = do_hold;
        flush_fetch  = br_taken;
        flush_decode = br_taken;
    end

    p_flush_beats_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (!hold_fetch && !hold_decode && !ex_bubble && flush_fetch && flush_decode));
    p_quiet_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |-> (!flush_fetch && !flush_decode));
endmodule

// File: rtl/hazard_unit.sv
// Hazard controller for a five-stage integer pipeline: operand bypass selects,
// load-use hold with execute bubble, and branch flush.
// Assumes: purely combinational; clk/rst_n only clock the embedded checks.
module hazard_unit
    import hzu_pkg::*;
#(
    parameter int REG_ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] id_src1,
    input  logic [REG_ADDR_W-1:0] id_src2,
    input  logic [REG_ADDR_W-1:0] ex_src1,
    input  logic [REG_ADDR_W-1:0] ex_src2,
    input  logic [REG_ADDR_W-1:0] ex_dst,
    input  logic                  ex_wr,
    input  logic                  ex_load,
    input  logic [REG_ADDR_W-1:0] mem_dst,
    input  logic                  mem_wr,
    input  logic [REG_ADDR_W-1:0] wb_dst,
    input  logic                  wb_wr,
    input  logic                  br_taken,
    output logic [1:0]            opa_sel,
    output logic [1:0]            opb_sel,
    output logic                  hold_fetch,
    output logic                  hold_decode,
    output logic                  ex_bubble,
    output logic                  flush_fetch,
    output logic                  flush_decode
);
    localparam int NUM_OPND = 2;

    logic [REG_ADDR_W-1:0] opnd_src [NUM_OPND];
    opnd_src_e             opnd_sel [NUM_OPND];
    logic                  load_hit;

    // Gather the execute source indices so each operand gets an identical selector.
    always_comb begin
        opnd_src[0] = ex_src1;
        opnd_src[1] = ex_src2;
    end

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        opnd_bypass_sel #(.AW(REG_ADDR_W)) u_sel (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (opnd_src[g]),
            .mem_dst (mem_dst),
            .mem_wr  (mem_wr),
            .wb_dst  (wb_dst),
            .wb_wr   (wb_wr),
            .sel     (opnd_sel[g])
        );
    end

    assign opa_sel = opnd_sel[0];
    assign opb_sel = opnd_sel[1];

    load_use_detect #(.AW(REG_ADDR_W)) u_luse (
        .clk     (clk),
        .rst_n   (rst_n),
        .id_src1 (id_src1),
        .id_src2 (id_src2),
        .ex_dst  (ex_dst),
        .ex_wr   (ex_wr),
        .ex_load (ex_load),
        .hit     (load_hit)
    );

    pipe_flow_ctrl u_flow (
        .clk          (clk),
        .rst_n        (rst_n),
        .br_taken     (br_taken),
        .load_hit     (load_hit),
        .hold_fetch   (hold_fetch),
        .hold_decode  (hold_decode),
        .ex_bubble    (ex_bubble),
        .flush_fetch  (flush_fetch),
        .flush_decode (flush_decode)
    );

    p_no_code3_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (opa_sel != 2'b11) && (opb_sel != 2'b11));
    p_hold_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_fetch == hold_decode) && (hold_decode == ex_bubble));
    p_hold_not_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_fetch && flush_fetch));
endmodule

// File: tb/test_hazard_unit.sv
module test_hazard_unit;
    localparam int AW = 5;
    localparam int SPAN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] id_src1 = '0, id_src2 = '0, ex_src1 = '0, ex_src2 = '0;
    logic [AW-1:0] ex_dst = '0, mem_dst = '0, wb_dst = '0;
    logic ex_wr = 1'b0, ex_load = 1'b0, mem_wr = 1'b0, wb_wr = 1'b0, br_taken = 1'b0;
    logic [1:0] opa_sel, opb_sel;
    logic hold_fetch, hold_decode, ex_bubble, flush_fetch, flush_decode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hazard_unit #(.REG_ADDR_W(AW)) i_hazard_unit (
        .clk(clk), .rst_n(rst_n),
        .id_src1(id_src1), .id_src2(id_src2),
        .ex_src1(ex_src1), .ex_src2(ex_src2),
        .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wr(mem_wr),
        .wb_dst(wb_dst), .wb_wr(wb_wr), .br_taken(br_taken),
        .opa_sel(opa_sel), .opb_sel(opb_sel),
        .hold_fetch(hold_fetch), .hold_decode(hold_decode), .ex_bubble(ex_bubble),
        .flush_fetch(flush_fetch), .flush_decode(flush_decode)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Expected select: 2 memory, 1 write-back, 0 regfile.
    function automatic int exp_src(int rs, int md, int mw, int wd, int ww);
        if (rs != 0 && mw != 0 && md == rs) return 2;
        if (rs != 0 && ww != 0 && wd == rs) return 1;
        return 0;
    endfunction

    function automatic string fwd_tag(int rs, int md, int mw, int wd, int ww);
        if (rs == 0) return "R4";
        if (mw != 0 && md == rs && ww != 0 && wd == rs) return "R3";
        if (mw != 0 && md == rs) return "R1";
        if (ww != 0 && wd == rs) return "R2";
        if (md == rs || wd == rs) return "R5";
        return "R12";
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Idle state during reset: regfile selects, no hold, no flush (R10, R12).
        chk("R12", "reset opa_sel", opa_sel, 0);
        chk("R12", "reset opb_sel", opb_sel, 0);
        chk("R10", "reset hold_fetch", hold_fetch, 0);
        chk("R10", "reset flush_fetch", flush_fetch, 0);
        chk("R10", "reset flush_decode", flush_decode, 0);
        rst_n = 1'b1;

        // Bypass sweep; operand B always uses a different index (R11).
        for (int r = 0; r < SPAN; r++)
        for (int m = 0; m < SPAN; m++)
        for (int mw = 0; mw < 2; mw++)
        for (int w = 0; w < SPAN; w++)
        for (int ww = 0; ww < 2; ww++) begin
            int rb;
            rb = (r + 1) % SPAN;
            @(negedge clk);
            ex_src1 = AW'(r); ex_src2 = AW'(rb);
            mem_dst = AW'(m); mem_wr = 1'(mw);
            wb_dst = AW'(w);  wb_wr = 1'(ww);
            #2;
            chk(fwd_tag(r, m, mw, w, ww), "opa_sel", opa_sel, exp_src(r, m, mw, w, ww));
            chk({fwd_tag(rb, m, mw, w, ww), " R11"}, "opb_sel", opb_sel,
                exp_src(rb, m, mw, w, ww));
        end

        // Hold/flush sweep.
        mem_wr = 1'b0; wb_wr = 1'b0;
        for (int a = 0; a < SPAN; a++)
        for (int b = 0; b < SPAN; b++)
        for (int d = 0; d < SPAN; d++)
        for (int wr = 0; wr < 2; wr++)
        for (int ld = 0; ld < 2; ld++)
        for (int bt = 0; bt < 2; bt++) begin
            bit match, luse, ehold;
            string tag;
            @(negedge clk);
            id_src1 = AW'(a); id_src2 = AW'(b);
            ex_dst = AW'(d); ex_wr = 1'(wr); ex_load = 1'(ld); br_taken = 1'(bt);
            #2;
            match = (d != 0) && (a == d || b == d);
            luse = match && ld != 0 && wr != 0;
            ehold = luse && bt == 0;
            if (bt != 0)                     tag = "R9";
            else if (luse)                   tag = "R6";
            else if (match && ld == 0)       tag = "R7";
            else if (ld != 0)                tag = "R8";
            else                             tag = "R10";
            chk(tag, "hold_fetch", hold_fetch, int'(ehold));
            chk(tag, "hold_decode", hold_decode, int'(ehold));
            chk(tag, "ex_bubble", ex_bubble, int'(ehold));
            chk(bt != 0 ? "R9" : "R10", "flush_fetch", flush_fetch, bt);
            chk(bt != 0 ? "R9" : "R10", "flush_decode", flush_decode, bt);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule